// File: doc/BRIEF.md
# SPI Serial Bit Clock Generator

This block derives the serial bit clock of an SPI master from a faster reference clock. The division is done in two stages. An even prescaler emits an enable strobe every DIVIDE/2 reference cycles. A second counter counts RATE+1 of those strobes for every half period of the bit clock. One full bit period is therefore DIVIDE × (1 + RATE) reference cycles, so the bit rate is the reference frequency divided by DIVIDE × (1 + RATE). Software picks the two divisors for a target frequency and writes them, with a timeout value, as one configuration word. The timeout value is passed on unchanged to the transfer logic.

The generator runs only while the transfer-active input is high. While that input is low, the clock rests at the idle level set by the polarity input and both counters are held cleared. Each time a transfer starts, the clock begins from the idle level, and its first transition comes a full half period later. With every transition the block also gives a one-cycle strobe: a leading strobe when the clock leaves its idle level and a trailing strobe when it returns. The shift logic uses these strobes to launch and sample data. Illegal divisor values are not rejected. They are corrected when the word is written.

Top module: `spi_bitclk_gen`

## Requirements
- R1: After synchronous reset, the clock output equals `cpol`, both strobes are low, `timeout_cfg` is zero, and the timing is DIVIDE=2 with RATE=0, which gives a half period of one reference cycle.
- R2: The configuration word holds RATE in bits [7:0], DIVIDE in bits [15:8] and the timeout in bits [31:16]. A write is taken when `cfg_wr` is high at a clock edge. The timeout shows on `timeout_cfg` one cycle later.
- R3: A written DIVIDE with bit 0 set is used with bit 0 cleared. For example, 5 acts as 4 and 255 acts as 254.
- R4: A written DIVIDE of 0 or 1 acts as 2.
- R5: While `xfer_active` is high, the clock toggles every (DIVIDE/2)·(RATE+1) reference cycles. RATE may take any value from 0 to 255.
- R6: `lead_stb` is high for exactly one cycle, in the same cycle that the clock output leaves its idle level. `trail_stb` is high for exactly one cycle, in the same cycle that the clock output returns to idle. The two are never high together.
- R7: The idle level of the clock output equals `cpol`, and the active level is its inverse.
- R8: One cycle after `xfer_active` is sampled low, the clock output is at idle and both strobes are low. A new transfer restarts both counters, so the first transition comes a full half period after `xfer_active` is first sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_word | input | 32 | Timeout, DIVIDE and RATE fields |
| xfer_active | input | 1 | Runs the generator while high |
| cpol | input | 1 | Idle level of the bit clock |
| sclk | output | 1 | Serial bit clock |
| lead_stb | output | 1 | One-cycle strobe when the clock leaves idle |
| trail_stb | output | 1 | One-cycle strobe when the clock returns to idle |
| timeout_cfg | output | 16 | Stored timeout field |

## Verification
Let N be the half period, (DIVIDE/2)·(RATE+1). The first `sclk` transition and the first `lead_stb` are due on the N-th rising edge after `xfer_active` is first sampled high. The first `trail_stb` is due on edge 2N and the second leading strobe on edge 3N. The stored timeout is due one edge after the write, and the return to idle one edge after `xfer_active` drops. The bench drives every input on a falling edge and counts rising edges from there. It samples at the next falling edge, so each check reads the exact cycle in which a result is due and can catch an early or late edge by a single cycle.

// File: rtl/sbclk_pkg.sv
// Shared constants and types for the SPI bit clock generator.
// Assumes: field widths sum to the configuration word width used by the top.
package sbclk_pkg;
    localparam int unsigned TMO_BITS  = 16;
    localparam int unsigned DIV_BITS  = 8;
    localparam int unsigned RATE_BITS = 8;

    // Phase of the bit clock relative to its idle level
    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_ACTIVE = 1'b1
    } phase_e;
endpackage

// File: rtl/sbclk_timing.sv
// Configuration register for the bit clock generator.
// Splits the written word into rate, divide and timeout fields and stores
// half of the sanitized divide value (odd values lose bit 0, 0 and 1 become 2).
// Assumes: DIV_W >= 2.
module sbclk_timing #(
    parameter int unsigned TMO_W  = sbclk_pkg::TMO_BITS,
    parameter int unsigned DIV_W  = sbclk_pkg::DIV_BITS,
    parameter int unsigned RATE_W = sbclk_pkg::RATE_BITS,
    localparam int unsigned WORD_W = TMO_W + DIV_W + RATE_W,
    localparam int unsigned HALF_W = DIV_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    output logic [HALF_W-1:0] half_div,
    output logic [RATE_W-1:0] rate,
    output logic [TMO_W-1:0]  tmo
);
    localparam logic [HALF_W-1:0] HALF_MIN = 1;

    logic [DIV_W-1:0]  div_raw;
    logic [HALF_W-1:0] half_new;

    assign div_raw = wr_word[RATE_W +: DIV_W];

    // Halve the divisor (drops bit 0) and clamp to the minimum of one
    always_comb begin
        half_new = div_raw[DIV_W-1:1];
        if (half_new == '0) half_new = HALF_MIN;
    end

    // Capture the fields on a write; reset to the fastest legal setting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_div <= HALF_MIN;
            rate     <= '0;
            tmo      <= '0;
        end else if (wr_en) begin
            half_div <= half_new;
            rate     <= wr_word[RATE_W-1:0];
            tmo      <= wr_word[RATE_W+DIV_W +: TMO_W];
        end
    end

    assert_half_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> half_div != '0);
    assert_rate_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rate == $past(wr_word[RATE_W-1:0]));
endmodule

// File: rtl/sbclk_prescale.sv
// First division stage: emits a one-cycle enable every half_div reference
// cycles while run is high; held cleared while run is low.
// Assumes: half_div >= 1.
module sbclk_prescale #(
    parameter int unsigned HALF_W = sbclk_pkg::DIV_BITS - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] half_div,
    output logic              stb
);
    localparam logic [HALF_W-1:0] ONE = 1;

    logic [HALF_W-1:0] pcnt;
    logic              at_end;

    // Terminal count; >= keeps the counter bounded if the setting shrinks
    assign at_end = (pcnt >= half_div - ONE);
    assign stb    = run && at_end;

    // Count reference cycles within one prescaler period
    always_ff @(posedge clk) begin
        if (!rst_n)      pcnt <= '0;
        else if (!run)   pcnt <= '0;
        else if (at_end) pcnt <= '0;
        else             pcnt <= pcnt + ONE;
    end

    assert_pcnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run) && $stable(half_div) |-> pcnt < half_div);
    assert_idle_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> pcnt == '0);
endmodule

// File: rtl/sbclk_halfcnt.sv
// Second division stage: counts rate+1 prescaler enables and flags the
// cycle that ends each half period of the bit clock.
// Assumes: stb is only high while run is high.
module sbclk_halfcnt #(
    parameter int unsigned RATE_W = sbclk_pkg::RATE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              stb,
    input  logic [RATE_W-1:0] rate,
    output logic              half_tick
);
    localparam logic [RATE_W-1:0] ONE = 1;

    logic [RATE_W-1:0] rcnt;
    logic              at_end;

    assign at_end    = (rcnt >= rate);
    assign half_tick = stb && at_end;

    // Count enables within one half period
    always_ff @(posedge clk) begin
        if (!rst_n)         rcnt <= '0;
        else if (!run)      rcnt <= '0;
        else if (half_tick) rcnt <= '0;
        else if (stb)       rcnt <= rcnt + ONE;
    end

    assert_rcnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run) && $stable(rate) |-> rcnt <= rate);
    assert_tick_needs_stb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        half_tick |-> stb && run);
endmodule

// File: rtl/sbclk_edge.sv
// Output stage: holds the clock phase, toggles it on each half-period tick
// and registers the leading and trailing strobes alongside the phase change.
// Assumes: cpol is quasi-static while a transfer runs.
module sbclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic half_tick,
    input  logic cpol,
    output logic sclk,
    output logic lead,
    output logic trail
);
    import sbclk_pkg::*;

    phase_e ph;

    // Track phase and emit the strobe matching the direction of each toggle
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ph    <= PH_IDLE;
            lead  <= 1'b0;
            trail <= 1'b0;
        end else begin
            lead  <= half_tick && (ph == PH_IDLE);
            trail <= half_tick && (ph == PH_ACTIVE);
            if (half_tick) ph <= (ph == PH_IDLE) ? PH_ACTIVE : PH_IDLE;
        end
    end

    // Map the phase onto the selected idle polarity
    assign sclk = (ph == PH_ACTIVE) ^ cpol;

    assert_lead_on_leave_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run && half_tick && ph == PH_IDLE |=> lead && ph == PH_ACTIVE);
    assert_trail_on_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run && half_tick && ph == PH_ACTIVE |=> trail && ph == PH_IDLE);
    assert_stb_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead && trail));
    assert_lead_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lead |=> !lead);
endmodule

// File: rtl/spi_bitclk_gen.sv
// SPI bit clock generator top: configuration register, even prescaler,
// half-period counter and output stage. Bit period is DIVIDE*(RATE+1)
// reference cycles. Assumes rst_n is synchronous to clk.
module spi_bitclk_gen #(
    parameter int unsigned TMO_W  = sbclk_pkg::TMO_BITS,
    parameter int unsigned DIV_W  = sbclk_pkg::DIV_BITS,
    parameter int unsigned RATE_W = sbclk_pkg::RATE_BITS,
    localparam int unsigned WORD_W = TMO_W + DIV_W + RATE_W,
    localparam int unsigned HALF_W = DIV_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [WORD_W-1:0] cfg_word,
    input  logic              xfer_active,
    input  logic              cpol,
    output logic              sclk,
    output logic              lead_stb,
    output logic              trail_stb,
    output logic [TMO_W-1:0]  timeout_cfg
);
    logic [HALF_W-1:0] half_div;
    logic [RATE_W-1:0] rate;
    logic              pre_stb;
    logic              half_tick;

    sbclk_timing #(.TMO_W(TMO_W), .DIV_W(DIV_W), .RATE_W(RATE_W)) u_timing (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_word(cfg_word),
        .half_div(half_div), .rate(rate), .tmo(timeout_cfg)
    );

    sbclk_prescale #(.HALF_W(HALF_W)) u_prescale (
        .clk(clk), .rst_n(rst_n), .run(xfer_active),
        .half_div(half_div), .stb(pre_stb)
    );

    sbclk_halfcnt #(.RATE_W(RATE_W)) u_halfcnt (
        .clk(clk), .rst_n(rst_n), .run(xfer_active), .stb(pre_stb),
        .rate(rate), .half_tick(half_tick)
    );

    sbclk_edge u_edge (
        .clk(clk), .rst_n(rst_n), .run(xfer_active), .half_tick(half_tick),
        .cpol(cpol), .sclk(sclk), .lead(lead_stb), .trail(trail_stb)
    );

    assert_tmo_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> timeout_cfg == $past(cfg_word[RATE_W+DIV_W +: TMO_W]));
    assert_idle_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_active |=> sclk == cpol && !lead_stb && !trail_stb);
    assert_lead_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lead_stb |-> sclk != cpol);
    assert_trail_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trail_stb |-> sclk == cpol);
endmodule

// File: tb/spi_bitclk_gen_bench.sv
`timescale 1ns/1ps
module spi_bitclk_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_word = '0;
    logic        xfer_active = 1'b0;
    logic        cpol = 1'b0;
    logic        sclk, lead_stb, trail_stb;
    logic [15:0] timeout_cfg;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    spi_bitclk_gen u_spi_bitclk_gen (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
        .xfer_active(xfer_active), .cpol(cpol), .sclk(sclk),
        .lead_stb(lead_stb), .trail_stb(trail_stb), .timeout_cfg(timeout_cfg)
    );

    // Vectors: raw divide, rate, polarity, timeout, expected half period.
    // Entry 3 exercises R3 (5 -> 4), entries 4/5 exercise R4 (0,1 -> 2),
    // entry 6 exercises R3 at the top end (255 -> 254).
    localparam int NV = 9;
    localparam logic [7:0]  V_DIV [NV] = '{8'd2, 8'd4, 8'd2, 8'd5, 8'd0, 8'd1, 8'd255, 8'd10, 8'd6};
    localparam logic [7:0]  V_RATE[NV] = '{8'd0, 8'd0, 8'd3, 8'd1, 8'd2, 8'd0, 8'd0,   8'd4,  8'd255};
    localparam logic        V_POL [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0,  1'b1,  1'b0};
    localparam logic [15:0] V_TMO [NV] = '{16'h0001, 16'hFFFF, 16'h1234, 16'h8000, 16'h00FF,
                                           16'hA5A5, 16'h0F0F, 16'h7FFF, 16'hC3C3};
    localparam int          V_HALF[NV] = '{1, 2, 4, 4, 3, 1, 127, 25, 768};

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic write_cfg(input logic [7:0] dv, input logic [7:0] rt, input logic [15:0] tm);
        @(negedge clk);
        cfg_word = {tm, dv, rt};
        cfg_wr   = 1'b1;
        @(negedge clk);
        cfg_wr   = 1'b0;
    endtask

    // Run one transfer; check edge times 1N, 2N, 3N and the return to idle
    task automatic run_transfer(input logic pol, input int half, input string tag);
        int k = 0;
        int l1 = -1, l2 = -1, t1 = -1;
        bit prev_lead = 1'b0;
        bit early = 1'b0;
        xfer_active = 1'b1;
        while (k < 3 * half + 2) begin
            @(negedge clk);
            k++;
            if (lead_stb) begin
                if (l1 < 0) l1 = k; else if (l2 < 0) l2 = k;
                check(sclk != pol, "R7 active level at lead", sclk, !pol);
            end
            if (trail_stb) begin
                if (t1 < 0) t1 = k;
                check(sclk == pol, "R7 idle level at trail", sclk, pol);
            end
            if (lead_stb && prev_lead) check(1'b0, "R6 lead wider than one cycle", 2, 1);
            if (lead_stb && trail_stb) check(1'b0, "R6 both strobes high", 1, 0);
            if (k < half && sclk != pol) early = 1'b1;
            prev_lead = lead_stb;
        end
        check(!early, {tag, " R8 clock moved before first half period"}, early, 0);
        check(l1 == half,     {tag, " R5 first lead"},  l1, half);
        check(t1 == 2 * half, {tag, " R6 first trail"}, t1, 2 * half);
        check(l2 == 3 * half, {tag, " R5 second lead"}, l2, 3 * half);
        xfer_active = 1'b0;
        @(negedge clk);
        check(sclk == pol && !lead_stb && !trail_stb, {tag, " R8 idle after stop"},
              {sclk, lead_stb, trail_stb}, {pol, 2'b00});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(sclk == 1'b0 && !lead_stb && !trail_stb, "R1 outputs in reset",
              {sclk, lead_stb, trail_stb}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(timeout_cfg == 16'h0, "R1 timeout after reset", timeout_cfg, 0);
        check(sclk == cpol, "R7 idle level after reset", sclk, cpol);
        // R1: default timing gives a one-cycle half period
        run_transfer(1'b0, 1, "R1 default timing");

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            cpol = V_POL[i];
            write_cfg(V_DIV[i], V_RATE[i], V_TMO[i]);
            check(timeout_cfg == V_TMO[i], "R2 timeout field", timeout_cfg, V_TMO[i]);
            check(sclk == V_POL[i], "R7 idle level", sclk, V_POL[i]);
            run_transfer(V_POL[i], V_HALF[i], $sformatf("vec%0d", i));
        end

        // R8: abort mid half period, then restart from the idle level
        cpol = 1'b0;
        write_cfg(8'd8, 8'd0, 16'h0042);
        xfer_active = 1'b1;
        repeat (3) @(negedge clk);
        xfer_active = 1'b0;
        @(negedge clk);
        check(sclk == 1'b0 && !lead_stb, "R8 idle after abort", sclk, 0);
        run_transfer(1'b0, 4, "R8 restart");

        // R2: write with no transfer running leaves the clock idle
        cpol = 1'b1;
        write_cfg(8'd4, 8'd1, 16'hBEEF);
        check(timeout_cfg == 16'hBEEF, "R2 timeout update", timeout_cfg, 16'hBEEF);
        check(sclk == 1'b1 && !lead_stb && !trail_stb, "R8 no activity while stopped",
              {sclk, lead_stb, trail_stb}, 3'b100);
        run_transfer(1'b1, 4, "R5 after rewrite");

        summary();
    end
endmodule